// File: doc/BRIEF.md
# TLB Entry Maintenance Unit

This block holds a 32-entry translation lookaside buffer and the staging registers through which a system coprocessor maintains it. Software loads the staging registers (index, entry high word, the two entry low words and the page mask) through a single-cycle register-write port. It then fires one of three maintenance operations with an operation strobe. A read copies an indexed entry into the staging registers. A write stores the staged values into an indexed entry. A probe searches every entry for one that translates the staged high word.

The block normalizes stored values. A write forces the page mask into legal bit pairs, clears the virtual page bits that the mask covers, and strips each low word of its per-half global bit while folding the two global bits into one entry flag. A read puts that flag back into each low word. A probe miss is reported by setting the top bit of the index register. Each operation takes one clock and answers with a one-cycle done pulse. An illegal entry number raises an error pulse together with done.

Top module: `tlb_maint_unit`

## Requirements
- R1: After reset all staged registers read zero, `op_done` and `op_err` are low, and every buffer entry holds zero, so reading any entry returns all-zero words.
- R2: A register write with `reg_wr_en` high loads `reg_wr_data` into the staged register picked by `reg_wr_sel`: 0 index, 1 entry high, 2 low word 0, 3 low word 1, 4 page mask. The value shows on the matching output after the clock edge. Select codes 5 to 7 change nothing.
- R3: `op_code` selects the operation when `op_valid` is high: 0 none, 1 read, 2 write, 3 probe. Every strobe, including code 0 and strobes on consecutive cycles, gives exactly one `op_done` pulse in the next cycle. Code 0 changes no state, and `op_done` stays low when there is no strobe.
- R4: On a write, the stored page mask keeps only the 12-bit field at bits 24:13. The field becomes (m AND 0xAAA) OR ((m AND 0xAAA) >> 1), and every bit outside the field is zero.
- R5: On a write, the stored entry high word equals the staged one with the bits under the sanitised mask cleared. The virtual page field is bits 31:13, and the address-space id is bits 7:0.
- R6: On a write, each low word is stored ANDed with 0x03FFFFFE. The entry is global only when bit 0, the global bit, is set in both staged low words.
- R7: A read returns the stored high word and page mask unchanged. It returns each stored low word ANDed with 0x3FFFFFFF, with bit 0 replaced by the entry's global flag. The staged index is not changed.
- R8: A probe hit writes the matching entry number into the index register. An entry matches when the virtual page bits agree outside its stored mask and, unless the entry is global, the address-space ids agree.
- R9: When several entries match a probe, the lowest-numbered one wins.
- R10: A probe that matches no entry writes 0x80000000 into the index register.
- R11: The entry number is index bits 5:0, and higher index bits are ignored. A read or write whose entry number is 32 or more changes neither the buffer nor the staged registers, and it raises `op_err` in the same cycle as `op_done`.
- R12: When a software write and an operation update the same staged register in one cycle, the operation's value wins. A software write to a register the operation leaves alone still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Staged register write strobe |
| reg_wr_sel | input | 3 | Staged register select |
| reg_wr_data | input | 32 | Staged register write data |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 2 | Operation code |
| op_done | output | 1 | One-cycle completion pulse |
| op_err | output | 1 | Illegal entry number, pulses with done |
| index_q | output | 32 | Staged index register |
| entry_hi_q | output | 32 | Staged entry high word |
| entry_lo0_q | output | 32 | Staged low word 0 |
| entry_lo1_q | output | 32 | Staged low word 1 |
| page_mask_q | output | 32 | Staged page mask |

## Verification
The buffer contents are hidden, so a wrong stored entry shows up only through a later operation. Bad normalization shows at the staged outputs one cycle after a read-back. A bad mask, global flag or address-space id shows as the wrong winner or a false miss one cycle after a probe. For that reason every write in the bench is followed by a read-back or a probe that crosses mask, global and priority cases. A wrong override or illegal-index path corrupts a staged register, and this is visible in the cycle right after the strobe.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;

  localparam int TLB_DW   = 32;
  localparam int MASK_LSB = 13;
  localparam int MASK_W   = 12;
  localparam int ASID_W   = 8;

  localparam logic [TLB_DW-1:0] VPN2_BITS  = 32'hFFFF_E000;
  localparam logic [MASK_W-1:0] PAIR_HI    = 12'hAAA;
  localparam logic [TLB_DW-1:0] LO_KEEP_WR = 32'h03FF_FFFE;
  localparam logic [TLB_DW-1:0] LO_KEEP_RD = 32'h3FFF_FFFF;
  localparam logic [TLB_DW-1:0] PROBE_MISS = 32'h8000_0000;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_PROBE = 2'b11
  } tlb_op_e;

  typedef enum logic [2:0] {
    SEL_INDEX = 3'd0,
    SEL_HI    = 3'd1,
    SEL_LO0   = 3'd2,
    SEL_LO1   = 3'd3,
    SEL_MASK  = 3'd4
  } stage_sel_e;

  typedef struct packed {
    logic [TLB_DW-1:0] hi;
    logic [TLB_DW-1:0] lo0;
    logic [TLB_DW-1:0] lo1;
    logic [TLB_DW-1:0] pm;
    logic              glob;
  } tlb_entry_t;

  // raw mask field out of a page-mask word
  function automatic logic [MASK_W-1:0] mask_field(input logic [TLB_DW-1:0] pm);
    return pm[MASK_LSB +: MASK_W];
  endfunction

  // force the field into whole pairs driven by the upper bit of each pair
  function automatic logic [MASK_W-1:0] legal_pairs(input logic [MASK_W-1:0] m);
    logic [MASK_W-1:0] top;
    top = m & PAIR_HI;
    return top | (top >> 1);
  endfunction

  function automatic logic [TLB_DW-1:0] place_mask(input logic [MASK_W-1:0] m);
    return TLB_DW'(m) << MASK_LSB;
  endfunction

  function automatic logic [TLB_DW-1:0] hi_for_store(input logic [TLB_DW-1:0] hi,
                                                     input logic [MASK_W-1:0] m);
    return hi & ~place_mask(m);
  endfunction

  function automatic logic [TLB_DW-1:0] lo_for_store(input logic [TLB_DW-1:0] lo);
    return lo & LO_KEEP_WR;
  endfunction

  function automatic logic [TLB_DW-1:0] lo_for_read(input logic [TLB_DW-1:0] lo,
                                                    input logic g);
    logic [TLB_DW-1:0] r;
    r    = lo & LO_KEEP_RD;
    r[0] = g;
    return r;
  endfunction

  // page compare outside the stored mask, id compare unless global
  function automatic logic entry_hits(input tlb_entry_t e, input logic [TLB_DW-1:0] key);
    logic [TLB_DW-1:0] care;
    care = VPN2_BITS & ~e.pm;
    return (((e.hi ^ key) & care) == '0) &&
           (e.glob || (e.hi[ASID_W-1:0] == key[ASID_W-1:0]));
  endfunction

endpackage

// File: rtl/tlbm_stage_regs.sv
module tlbm_stage_regs
  import tlbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [TLB_DW-1:0] wr_data,
  input  logic              upd_index,
  input  logic [TLB_DW-1:0] new_index,
  input  logic              upd_entry,
  input  logic [TLB_DW-1:0] new_hi,
  input  logic [TLB_DW-1:0] new_lo0,
  input  logic [TLB_DW-1:0] new_lo1,
  input  logic [TLB_DW-1:0] new_pm,
  output logic [TLB_DW-1:0] index_q,
  output logic [TLB_DW-1:0] hi_q,
  output logic [TLB_DW-1:0] lo0_q,
  output logic [TLB_DW-1:0] lo1_q,
  output logic [TLB_DW-1:0] pm_q
);

  stage_sel_e sel;
  assign sel = stage_sel_e'(wr_sel);

  // software first, operation results last so they take precedence
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q <= '0;
      hi_q    <= '0;
      lo0_q   <= '0;
      lo1_q   <= '0;
      pm_q    <= '0;
    end else begin
      if (wr_en) begin
        case (sel)
          SEL_INDEX: index_q <= wr_data;
          SEL_HI:    hi_q    <= wr_data;
          SEL_LO0:   lo0_q   <= wr_data;
          SEL_LO1:   lo1_q   <= wr_data;
          SEL_MASK:  pm_q    <= wr_data;
          default:   ;
        endcase
      end
      if (upd_index) index_q <= new_index;
      if (upd_entry) begin
        hi_q  <= new_hi;
        lo0_q <= new_lo0;
        lo1_q <= new_lo1;
        pm_q  <= new_pm;
      end
    end
  end

  assert_op_beats_sw_R12: assert property (@(posedge clk) disable iff (!rst_n)
    upd_entry |=> (hi_q == $past(new_hi)) && (pm_q == $past(new_pm)));

  assert_sw_hi_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd1 && !upd_entry) |=> hi_q == $past(wr_data));

  assert_bad_sel_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel > 3'd4 && !upd_entry && !upd_index) |=> $stable(hi_q) && $stable(index_q));

endmodule

// File: rtl/tlbm_entry_store.sv
module tlbm_entry_store
  import tlbm_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int AW = $clog2(ENTRIES)
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  tlb_entry_t         wdata,
  input  logic [AW-1:0]      raddr,
  output tlb_entry_t         rdata,
  input  logic [TLB_DW-1:0]  probe_key,
  output logic [ENTRIES-1:0] match_vec
);

  tlb_entry_t          slots [ENTRIES];
  logic [ENTRIES-1:0]  slot_we;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    tlb_entry_t slot_q;

    assign slot_we[i] = we && (waddr == AW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)          slot_q <= '0;
      else if (slot_we[i]) slot_q <= wdata;
    end

    assign slots[i]     = slot_q;
    assign match_vec[i] = entry_hits(slot_q, probe_key);

    assert_pairs_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((slot_q.pm & 32'h0155_4000) >> 1) == (slot_q.pm & 32'h00AA_A000) &&
      (slot_q.pm & ~32'h01FF_E000) == '0);
  end

  assign rdata = slots[raddr];

  assert_single_slot_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_we) && (!we -> slot_we == '0));

endmodule

// File: rtl/tlbm_first_hit.sv
module tlbm_first_hit #(
  parameter int ENTRIES = 32,
  localparam int AW = $clog2(ENTRIES)
)(
  input  logic [ENTRIES-1:0] match_vec,
  output logic               hit,
  output logic [AW-1:0]      hit_idx
);

  // scan from the top so the lowest set bit is the last one kept
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        hit     = 1'b1;
        hit_idx = AW'(i);
      end
    end
  end

endmodule

// File: rtl/tlb_maint_unit.sv
module tlb_maint_unit
  import tlbm_pkg::*;
#(
  parameter int ENTRIES  = 32,
  parameter int IDX_BITS = 6
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [2:0]  reg_wr_sel,
  input  logic [31:0] reg_wr_data,
  input  logic        op_valid,
  input  logic [1:0]  op_code,
  output logic        op_done,
  output logic        op_err,
  output logic [31:0] index_q,
  output logic [31:0] entry_hi_q,
  output logic [31:0] entry_lo0_q,
  output logic [31:0] entry_lo1_q,
  output logic [31:0] page_mask_q
);

  localparam int AW = $clog2(ENTRIES);

  tlb_op_e            opc;
  logic               fire_rd, fire_wr, fire_pr;
  logic [IDX_BITS-1:0] idx_field;
  logic               idx_legal;
  logic [AW-1:0]      slot;
  logic               illegal_op;
  logic               tlb_we, read_ok;
  logic [MASK_W-1:0]  clean_mask;
  tlb_entry_t         wentry, rentry;
  logic [ENTRIES-1:0] match_vec;
  logic               hit;
  logic [AW-1:0]      hit_idx;
  logic [TLB_DW-1:0]  probe_index;

  assign opc     = tlb_op_e'(op_code);
  assign fire_rd = op_valid && (opc == OP_READ);
  assign fire_wr = op_valid && (opc == OP_WRITE);
  assign fire_pr = op_valid && (opc == OP_PROBE);

  assign idx_field  = index_q[IDX_BITS-1:0];
  assign idx_legal  = int'(idx_field) < ENTRIES;
  assign slot       = idx_field[AW-1:0];
  assign illegal_op = (fire_rd || fire_wr) && !idx_legal;
  assign tlb_we     = fire_wr && idx_legal;
  assign read_ok    = fire_rd && idx_legal;

  // normalized entry image for an indexed write
  assign clean_mask  = legal_pairs(mask_field(page_mask_q));
  assign wentry.hi   = hi_for_store(entry_hi_q, clean_mask);
  assign wentry.pm   = place_mask(clean_mask);
  assign wentry.lo0  = lo_for_store(entry_lo0_q);
  assign wentry.lo1  = lo_for_store(entry_lo1_q);
  assign wentry.glob = entry_lo0_q[0] & entry_lo1_q[0];

  tlbm_entry_store #(.ENTRIES(ENTRIES)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (tlb_we),
    .waddr     (slot),
    .wdata     (wentry),
    .raddr     (slot),
    .rdata     (rentry),
    .probe_key (entry_hi_q),
    .match_vec (match_vec)
  );

  tlbm_first_hit #(.ENTRIES(ENTRIES)) u_pick (
    .match_vec (match_vec),
    .hit       (hit),
    .hit_idx   (hit_idx)
  );

  assign probe_index = hit ? TLB_DW'(hit_idx) : PROBE_MISS;

  tlbm_stage_regs u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .wr_sel    (reg_wr_sel),
    .wr_data   (reg_wr_data),
    .upd_index (fire_pr),
    .new_index (probe_index),
    .upd_entry (read_ok),
    .new_hi    (rentry.hi),
    .new_lo0   (lo_for_read(rentry.lo0, rentry.glob)),
    .new_lo1   (lo_for_read(rentry.lo1, rentry.glob)),
    .new_pm    (rentry.pm),
    .index_q   (index_q),
    .hi_q      (entry_hi_q),
    .lo0_q     (entry_lo0_q),
    .lo1_q     (entry_lo1_q),
    .pm_q      (page_mask_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_done <= 1'b0;
      op_err  <= 1'b0;
    end else begin
      op_done <= op_valid;
      op_err  <= illegal_op;
    end
  end

  assert_done_follows_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> op_done);

  assert_no_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !op_done);

  assert_err_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |-> op_done);

  assert_illegal_keeps_stage_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_op && !reg_wr_en) |=>
      (entry_hi_q == $past(entry_hi_q)) && (entry_lo0_q == $past(entry_lo0_q)) &&
      (page_mask_q == $past(page_mask_q)));

  assert_miss_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_pr && match_vec == '0) |=> index_q == PROBE_MISS);

  assert_hit_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_pr && match_vec != '0) |=> index_q < TLB_DW'(ENTRIES));

  assert_lowest_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> match_vec[hit_idx] &&
            ((match_vec & ((ENTRIES'(1) << hit_idx) - ENTRIES'(1))) == '0));

endmodule

// File: tb/sim_tlb_maint_unit.sv
module sim_tlb_maint_unit;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_wr_sel = '0;
  logic [31:0] reg_wr_data = '0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_code = '0;
  logic        op_done, op_err;
  logic [31:0] index_q, entry_hi_q, entry_lo0_q, entry_lo1_q, page_mask_q;

  always #2.5 clk = ~clk;

  tlb_maint_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .op_valid(op_valid), .op_code(op_code),
    .op_done(op_done), .op_err(op_err),
    .index_q(index_q), .entry_hi_q(entry_hi_q), .entry_lo0_q(entry_lo0_q),
    .entry_lo1_q(entry_lo1_q), .page_mask_q(page_mask_q)
  );

  typedef struct {
    int          grp;
    string       req;
    int          sel;
    logic [31:0] exp;
  } item_t;

  item_t sbq[$];
  int n_chk = 0, n_fail = 0, op_no = 0, done_seen = 0;
  bit finished = 0;

  // reference model
  logic [31:0] m_hi [32], m_lo0 [32], m_lo1 [32], m_pm [32];
  logic        m_g  [32];
  logic [31:0] s_idx = '0, s_hi = '0, s_lo0 = '0, s_lo1 = '0, s_pm = '0;

  function automatic logic [31:0] b_pm(input logic [31:0] pm);
    logic [31:0] r = '0;
    for (int k = 0; k < 6; k++)
      if (pm[14 + 2*k]) begin r[13 + 2*k] = 1'b1; r[14 + 2*k] = 1'b1; end
    return r;
  endfunction

  function automatic logic [31:0] b_lo_st(input logic [31:0] lo);
    logic [31:0] r = lo;
    r[31:26] = '0; r[0] = 1'b0;
    return r;
  endfunction

  function automatic logic [31:0] b_lo_rd(input logic [31:0] lo, input logic g);
    logic [31:0] r = lo;
    r[31:30] = '0; r[0] = g;
    return r;
  endfunction

  function automatic int b_probe(input logic [31:0] key);
    for (int i = 0; i < 32; i++) begin
      bit ok = 1;
      for (int b = 13; b < 32; b++)
        if (!m_pm[i][b] && (m_hi[i][b] != key[b])) ok = 0;
      if (!m_g[i] && (m_hi[i][7:0] != key[7:0])) ok = 0;
      if (ok) return i;
    end
    return -1;
  endfunction

  function automatic logic [31:0] get_act(input int sel);
    case (sel)
      0: return index_q;
      1: return entry_hi_q;
      2: return entry_lo0_q;
      3: return entry_lo1_q;
      4: return page_mask_q;
      default: return {31'd0, op_err};
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_wr(input logic [2:0] sel, input logic [31:0] d);
    case (sel)
      3'd0: s_idx = d;
      3'd1: s_hi  = d;
      3'd2: s_lo0 = d;
      3'd3: s_lo1 = d;
      3'd4: s_pm  = d;
      default: ;
    endcase
  endtask

  task automatic check_stage(input string req);
    chk(req, index_q, s_idx);
    chk(req, entry_hi_q, s_hi);
    chk(req, entry_lo0_q, s_lo0);
    chk(req, entry_lo1_q, s_lo1);
    chk(req, page_mask_q, s_pm);
  endtask

  task automatic wreg(input logic [2:0] sel, input logic [31:0] d, input string req = "R2");
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
    model_wr(sel, d);
    @(negedge clk);
    reg_wr_en = 1'b0;
    check_stage(req);
    chk({req, " R3 no done"}, {31'd0, op_done}, 32'd0);
  endtask

  // driver: drive the strobe, predict, push into the scoreboard
  task automatic run_op(input logic [1:0] code, input string req,
                        input bit with_wr = 0, input logic [2:0] wsel = 3'd0,
                        input logic [31:0] wdat = '0);
    logic [31:0] p_idx = s_idx, p_hi = s_hi, p_lo0 = s_lo0, p_lo1 = s_lo1, p_pm = s_pm;
    int  slot = int'(s_idx[5:0]);
    bit  legal = (slot < 32);
    bit  err;
    int  h;
    item_t it;
    op_valid = 1'b1; op_code = code;
    reg_wr_en = with_wr; reg_wr_sel = wsel; reg_wr_data = wdat;
    if (with_wr) model_wr(wsel, wdat);
    case (code)
      2'd1: if (legal) begin
        s_hi  = m_hi[slot];
        s_pm  = m_pm[slot];
        s_lo0 = b_lo_rd(m_lo0[slot], m_g[slot]);
        s_lo1 = b_lo_rd(m_lo1[slot], m_g[slot]);
      end
      2'd2: if (legal) begin
        m_pm[slot]  = b_pm(p_pm);
        m_hi[slot]  = p_hi & ~m_pm[slot];
        m_lo0[slot] = b_lo_st(p_lo0);
        m_lo1[slot] = b_lo_st(p_lo1);
        m_g[slot]   = p_lo0[0] & p_lo1[0];
      end
      2'd3: begin
        h = b_probe(p_hi);
        s_idx = (h < 0) ? 32'h8000_0000 : 32'(h);
      end
      default: ;
    endcase
    err = ((code == 2'd1) || (code == 2'd2)) && !legal;
    for (int s = 0; s < 6; s++) begin
      it.grp = op_no; it.req = req; it.sel = s;
      case (s)
        0: it.exp = s_idx;
        1: it.exp = s_hi;
        2: it.exp = s_lo0;
        3: it.exp = s_lo1;
        4: it.exp = s_pm;
        default: it.exp = {31'd0, err};
      endcase
      sbq.push_back(it);
    end
    op_no++;
    if (p_idx === 32'hx) $display("unreachable");
    @(negedge clk);
    op_valid = 1'b0; reg_wr_en = 1'b0; op_code = '0;
  endtask

  // monitor: one done pulse retires one operation's expectations
  always @(negedge clk) begin
    item_t it;
    if (rst_n && op_done) begin
      while (sbq.size() > 0 && sbq[0].grp == done_seen) begin
        it = sbq.pop_front();
        chk(it.req, get_act(it.sel), it.exp);
      end
      done_seen++;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_fail++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      m_hi[i] = '0; m_lo0[i] = '0; m_lo1[i] = '0; m_pm[i] = '0; m_g[i] = 1'b0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_stage("R1 reset");
    chk("R1 reset done", {31'd0, op_done}, 32'd0);
    chk("R1 reset err", {31'd0, op_err}, 32'd0);

    wreg(3'd0, 32'd5);
    run_op(2'd1, "R1 R7 zero entry");

    wreg(3'd5, 32'hDEAD_BEEF, "R2 unused sel");
    wreg(3'd7, 32'h1234_5678, "R2 unused sel");

    // entry 3: mask garbage, mixed global bits
    wreg(3'd0, 32'd3);
    wreg(3'd1, 32'h1234_5A5A);
    wreg(3'd2, 32'hFFFF_FFFF);
    wreg(3'd3, 32'h8000_0002);
    wreg(3'd4, 32'hF1AB_C123);
    run_op(2'd2, "R4 R5 R6 write");
    wreg(3'd1, 32'h0); wreg(3'd2, 32'h0); wreg(3'd3, 32'h0); wreg(3'd4, 32'h0);
    run_op(2'd1, "R4 R5 R6 R7 readback");
    wreg(3'd1, 32'h0);
    wreg(3'd0, 32'h0000_0143);
    run_op(2'd1, "R11 upper index bits ignored");

    // entry 7 global
    wreg(3'd0, 32'd7);
    wreg(3'd1, 32'h0ACE_0011);
    wreg(3'd2, 32'h0000_0001);
    wreg(3'd3, 32'h0000_0001);
    wreg(3'd4, 32'h0);
    run_op(2'd2, "R6 global write");
    run_op(2'd1, "R7 global readback");
    wreg(3'd1, 32'h0ACE_0022);
    run_op(2'd3, "R8 global hit");

    // entry 9 private id 0x44
    wreg(3'd0, 32'd9);
    wreg(3'd1, 32'h5550_0044);
    wreg(3'd2, 32'h0000_0001);
    wreg(3'd3, 32'h0000_0000);
    run_op(2'd2, "R6 private write");
    wreg(3'd1, 32'h5550_0045);
    run_op(2'd3, "R8 R10 id mismatch miss");
    wreg(3'd1, 32'h5550_0044);
    run_op(2'd3, "R8 id match hit");

    // priority: 12 then 10 with same page
    wreg(3'd1, 32'h7770_0010);
    wreg(3'd2, 32'h0); wreg(3'd3, 32'h0);
    wreg(3'd0, 32'd12);
    run_op(2'd2, "R9 write high slot");
    wreg(3'd0, 32'd10);
    run_op(2'd2, "R9 write low slot");
    wreg(3'd0, 32'd0);
    run_op(2'd3, "R9 lowest wins");
    run_op(2'd1, "R3 back to back read");

    // masked compare on entry 14
    wreg(3'd0, 32'd14);
    wreg(3'd1, 32'h3333_4020);
    wreg(3'd2, 32'h1);
    wreg(3'd3, 32'h1);
    wreg(3'd4, 32'h0001_E000);
    run_op(2'd2, "R4 R5 masked write");
    wreg(3'd1, 32'h3333_C000);
    run_op(2'd3, "R8 masked hit");
    wreg(3'd1, 32'hFFFF_E0FF);
    run_op(2'd3, "R10 miss");

    // illegal indices
    wreg(3'd0, 32'd40);
    wreg(3'd1, 32'h1111_1111);
    run_op(2'd2, "R11 illegal write");
    wreg(3'd0, 32'd8);
    run_op(2'd1, "R11 slot untouched");
    wreg(3'd0, 32'h0000_003F);
    wreg(3'd1, 32'h2222_2222);
    run_op(2'd1, "R11 illegal read");

    run_op(2'd0, "R3 no-op");

    // same-cycle software write and operation
    wreg(3'd0, 32'd3);
    run_op(2'd1, "R12 op beats sw", 1'b1, 3'd1, 32'hCAFE_F00D);
    run_op(2'd1, "R12 sw index kept", 1'b1, 3'd0, 32'd5);

    repeat (3) @(negedge clk);
    chk("R3 every strobe answered", 32'(done_seen), 32'(op_no));
    chk("R3 scoreboard drained", 32'(sbq.size()), 32'd0);
    chk("R3 idle done", {31'd0, op_done}, 32'd0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule